// File: doc/BRIEF.md
# Memory User Bus Arbiter

This block shares one frame-buffer port among a set of memory users. Each user has a private request line and a private select line. All users share a single bus carrying a dword address, write data, read data, a strobe and a direction flag. A user does not send its transfer request to the arbiter. It keeps the request in two descriptor registers at the top of its own dword address space, and the arbiter fetches them over the shared bus once it has selected that user.

When the arbiter is idle it picks one requesting user. Users flagged as priority users, such as display line caches, win over all others, and among them the lowest index wins. The other users are taken in round-robin order. The arbiter raises the chosen select line and reads the command/count descriptor and then the start-address descriptor. It then moves the requested number of dwords between user addresses 0, 1, 2… and consecutive frame-buffer words, one dword per frame-buffer word. A frame-buffer error aborts the request early by dropping select.

The frame-buffer side is a plain request/acknowledge port. A request is held until the memory answers with either an acknowledge or an error.

Top module: `mu_bus_arbiter`

## Requirements
- R1: When any priority user (set in `PRIO_MASK`) is requesting at arbitration time, a priority user is granted, choosing the lowest-indexed one.
- R2: Non-priority users are granted in round-robin order. The search starts just past the last non-priority user served, and starts at user 0 after reset.
- R3: At most one select is high. A select stays high, unchanged, until its whole request is finished. It is then low for at least one cycle before any new grant, and no other user is granted in between.
- R4: The first bus access after a select rises is a read of user address 0xFFC. Bit 31 of that dword gives the direction (1 = user data is written to the frame buffer, 0 = frame-buffer data is read into the user). Bits 23:0 give the dword count.
- R5: The second bus access is a read of user address 0xFFD, which supplies the starting frame-buffer word address. Addresses 0xFFE and 0xFFF are never accessed.
- R6: For the write direction, user dwords are read from addresses 0, 1, … in turn, and each is written to frame-buffer word start+k in that order.
- R7: For the read direction, frame-buffer word start+k is read and written into user address k, for k counting up from 0.
- R8: A strobe cycle with the direction flag high carries the dword to be latched at the bus address on `bus_wdata_o`. With the flag low, the arbiter takes `bus_rdata_i` at the end of that strobe cycle.
- R9: A count of zero drops select right after the descriptor reads, with no frame-buffer request.
- R10: An error response on the frame-buffer port drops select at once. No further bus strobe or frame-buffer request follows for that user.
- R11: A frame-buffer request keeps its address, write flag and data unchanged until acknowledge or error.
- R12: While reset is active, no select, strobe or frame-buffer request is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mu_irq_i | input | NUM_MU | Per-user service request |
| mu_sel_o | output | NUM_MU | Per-user select, one-hot or zero |
| bus_addr_o | output | AW | Shared bus dword address |
| bus_wdata_o | output | DW | Shared bus data toward the user |
| bus_rdata_i | input | DW | Shared bus data from the selected user |
| bus_strobe_o | output | 1 | Bus access valid this cycle |
| bus_write_o | output | 1 | 1: user latches data, 0: user drives data |
| fb_req_o | output | 1 | Frame-buffer request |
| fb_we_o | output | 1 | Frame-buffer write enable |
| fb_addr_o | output | FB_AW | Frame-buffer word address |
| fb_wdata_o | output | DW | Frame-buffer write data |
| fb_rdata_i | input | DW | Frame-buffer read data, valid with acknowledge |
| fb_ack_i | input | 1 | Frame-buffer acknowledge |
| fb_err_i | input | 1 | Frame-buffer error response, aborts the request |

## Verification
The assertions assume that a user drops its request within one cycle of seeing its select fall, so a finished request is not granted twice. They also assume that the frame buffer raises acknowledge or error only while a request is pending, never both at once, and each for one cycle. The bench user models clear their request on the first falling clock edge after select drops. The bench memory model answers only a pending request, pulses exactly one of acknowledge or error, and uses a programmable wait count. The stimulus therefore stays within these assumptions while still covering latency, mid-burst requests from other users and an injected error.

// File: rtl/mu_arb_pkg.sv
package mu_arb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DESC_CMD,
    ST_DESC_ADR,
    ST_MU_RD,
    ST_FB_WR,
    ST_FB_RD,
    ST_MU_WR,
    ST_GAP
  } seq_state_e;
endpackage

// File: rtl/mu_arb_pick.sv
module mu_arb_pick #(
  parameter int                 NUM_MU    = 4,
  parameter logic [NUM_MU-1:0]  PRIO_MASK = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_MU-1:0] irq_i,
  input  logic              take_i,
  output logic              req_any_o,
  output logic [NUM_MU-1:0] gnt_o
);
  localparam int IW = (NUM_MU > 1) ? $clog2(NUM_MU) : 1;

  logic [IW-1:0] ptr_q;
  logic [IW-1:0] prio_idx, rr_idx, win_idx;
  logic          prio_hit, rr_hit;
  int            cand;

  always_comb begin
    prio_hit = 1'b0;
    prio_idx = '0;
    for (int i = NUM_MU - 1; i >= 0; i--) begin
      if (irq_i[i] && PRIO_MASK[i]) begin
        prio_hit = 1'b1;
        prio_idx = IW'(i);
      end
    end
    rr_hit = 1'b0;
    rr_idx = '0;
    cand   = 0;
    // descending offset so the nearest candidate after ptr wins
    for (int o = NUM_MU - 1; o >= 0; o--) begin
      cand = int'(ptr_q) + o;
      if (cand >= NUM_MU) cand = cand - NUM_MU;
      if (irq_i[cand] && !PRIO_MASK[cand]) begin
        rr_hit = 1'b1;
        rr_idx = IW'(cand);
      end
    end
    win_idx   = prio_hit ? prio_idx : rr_idx;
    req_any_o = prio_hit | rr_hit;
    gnt_o     = req_any_o ? (NUM_MU'(1) << win_idx) : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
    end else if (take_i && !prio_hit && rr_hit) begin
      ptr_q <= (rr_idx == IW'(NUM_MU - 1)) ? '0 : rr_idx + IW'(1);
    end
  end
endmodule

// File: rtl/mu_arb_seq.sv
module mu_arb_seq
  import mu_arb_pkg::*;
#(
  parameter int AW    = 12,
  parameter int DW    = 32,
  parameter int CW    = 24,
  parameter int FB_AW = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             accept_o,
  output logic             finish_o,
  output logic [AW-1:0]    bus_addr_o,
  output logic [DW-1:0]    bus_wdata_o,
  input  logic [DW-1:0]    bus_rdata_i,
  output logic             bus_strobe_o,
  output logic             bus_write_o,
  output logic             fb_req_o,
  output logic             fb_we_o,
  output logic [FB_AW-1:0] fb_addr_o,
  output logic [DW-1:0]    fb_wdata_o,
  input  logic [DW-1:0]    fb_rdata_i,
  input  logic             fb_ack_i,
  input  logic             fb_err_i
);
  localparam logic [AW-1:0] CMD_ADDR = {{(AW-2){1'b1}}, 2'b00};
  localparam logic [AW-1:0] ADR_ADDR = {{(AW-2){1'b1}}, 2'b01};
  localparam int            DIR_BIT  = DW - 1;

  seq_state_e        state_q, state_d;
  logic [CW-1:0]     cnt_q;
  logic [AW-1:0]     idx_q;
  logic [FB_AW-1:0]  fbaddr_q;
  logic [DW-1:0]     data_q;
  logic              to_fb_q;
  logic              last;
  logic              adv;

  assign last = (cnt_q == CW'(1));

  always_comb begin
    bus_strobe_o = 1'b0;
    bus_write_o  = 1'b0;
    bus_addr_o   = idx_q;
    fb_req_o     = 1'b0;
    fb_we_o      = 1'b0;
    unique case (state_q)
      ST_DESC_CMD: begin bus_strobe_o = 1'b1; bus_addr_o = CMD_ADDR; end
      ST_DESC_ADR: begin bus_strobe_o = 1'b1; bus_addr_o = ADR_ADDR; end
      ST_MU_RD:    bus_strobe_o = 1'b1;
      ST_MU_WR:    begin bus_strobe_o = 1'b1; bus_write_o = 1'b1; end
      ST_FB_WR:    begin fb_req_o = 1'b1; fb_we_o = 1'b1; end
      ST_FB_RD:    fb_req_o = 1'b1;
      default: ;
    endcase
  end

  assign bus_wdata_o = data_q;
  assign fb_addr_o   = fbaddr_q;
  assign fb_wdata_o  = data_q;
  assign accept_o    = (state_q == ST_IDLE) && start_i;

  always_comb begin
    state_d  = state_q;
    finish_o = 1'b0;
    adv      = 1'b0;
    unique case (state_q)
      ST_IDLE:     if (start_i) state_d = ST_DESC_CMD;
      ST_DESC_CMD: state_d = ST_DESC_ADR;
      ST_DESC_ADR: begin
        if (cnt_q == '0) begin
          state_d  = ST_GAP;
          finish_o = 1'b1;
        end else begin
          state_d = to_fb_q ? ST_MU_RD : ST_FB_RD;
        end
      end
      ST_MU_RD:    state_d = ST_FB_WR;
      ST_FB_WR: begin
        if (fb_err_i) begin
          state_d  = ST_GAP;
          finish_o = 1'b1;
        end else if (fb_ack_i) begin
          adv      = 1'b1;
          finish_o = last;
          state_d  = last ? ST_GAP : ST_MU_RD;
        end
      end
      ST_FB_RD: begin
        if (fb_err_i) begin
          state_d  = ST_GAP;
          finish_o = 1'b1;
        end else if (fb_ack_i) begin
          state_d = ST_MU_WR;
        end
      end
      ST_MU_WR: begin
        adv      = 1'b1;
        finish_o = last;
        state_d  = last ? ST_GAP : ST_FB_RD;
      end
      ST_GAP:      state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      idx_q    <= '0;
      fbaddr_q <= '0;
      data_q   <= '0;
      to_fb_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_DESC_CMD) begin
        to_fb_q <= bus_rdata_i[DIR_BIT];
        cnt_q   <= bus_rdata_i[CW-1:0];
      end
      if (state_q == ST_DESC_ADR) begin
        fbaddr_q <= bus_rdata_i[FB_AW-1:0];
        idx_q    <= '0;
      end
      if (state_q == ST_MU_RD) data_q <= bus_rdata_i;
      if (state_q == ST_FB_RD && fb_ack_i && !fb_err_i) data_q <= fb_rdata_i;
      if (adv) begin
        idx_q    <= idx_q + AW'(1);
        fbaddr_q <= fbaddr_q + FB_AW'(1);
        cnt_q    <= cnt_q - CW'(1);
      end
    end
  end
endmodule

// File: rtl/mu_bus_arbiter.sv
module mu_bus_arbiter #(
  parameter int                NUM_MU    = 4,
  parameter logic [NUM_MU-1:0] PRIO_MASK = 4'b1010,
  parameter int                AW        = 12,
  parameter int                DW        = 32,
  parameter int                CW        = 24,
  parameter int                FB_AW     = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_MU-1:0] mu_irq_i,
  output logic [NUM_MU-1:0] mu_sel_o,
  output logic [AW-1:0]     bus_addr_o,
  output logic [DW-1:0]     bus_wdata_o,
  input  logic [DW-1:0]     bus_rdata_i,
  output logic              bus_strobe_o,
  output logic              bus_write_o,
  output logic              fb_req_o,
  output logic              fb_we_o,
  output logic [FB_AW-1:0]  fb_addr_o,
  output logic [DW-1:0]     fb_wdata_o,
  input  logic [DW-1:0]     fb_rdata_i,
  input  logic              fb_ack_i,
  input  logic              fb_err_i
);
  logic              req_any, accept, finish;
  logic [NUM_MU-1:0] gnt, sel_q;

  mu_arb_pick #(.NUM_MU(NUM_MU), .PRIO_MASK(PRIO_MASK)) u_pick (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .irq_i     (mu_irq_i),
    .take_i    (accept),
    .req_any_o (req_any),
    .gnt_o     (gnt)
  );

  mu_arb_seq #(.AW(AW), .DW(DW), .CW(CW), .FB_AW(FB_AW)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (req_any),
    .accept_o     (accept),
    .finish_o     (finish),
    .bus_addr_o   (bus_addr_o),
    .bus_wdata_o  (bus_wdata_o),
    .bus_rdata_i  (bus_rdata_i),
    .bus_strobe_o (bus_strobe_o),
    .bus_write_o  (bus_write_o),
    .fb_req_o     (fb_req_o),
    .fb_we_o      (fb_we_o),
    .fb_addr_o    (fb_addr_o),
    .fb_wdata_o   (fb_wdata_o),
    .fb_rdata_i   (fb_rdata_i),
    .fb_ack_i     (fb_ack_i),
    .fb_err_i     (fb_err_i)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sel_q <= '0;
    else if (accept) sel_q <= gnt;
    else if (finish) sel_q <= '0;
  end

  assign mu_sel_o = sel_q;
endmodule

// File: rtl/mu_bus_arbiter_chk.sv
module mu_bus_arbiter_chk #(
  parameter int                NUM_MU    = 4,
  parameter logic [NUM_MU-1:0] PRIO_MASK = 4'b1010,
  parameter int                AW        = 12,
  parameter int                DW        = 32,
  parameter int                FB_AW     = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NUM_MU-1:0] mu_irq_i,
  input logic [NUM_MU-1:0] mu_sel_o,
  input logic [AW-1:0]     bus_addr_o,
  input logic              bus_strobe_o,
  input logic              bus_write_o,
  input logic              fb_req_o,
  input logic              fb_we_o,
  input logic [FB_AW-1:0]  fb_addr_o,
  input logic [DW-1:0]     fb_wdata_o,
  input logic              fb_ack_i,
  input logic              fb_err_i
);
  localparam logic [AW-1:0] CMD_ADDR = {{(AW-2){1'b1}}, 2'b00};
  localparam logic [AW-1:0] RSV_A    = {{(AW-2){1'b1}}, 2'b10};
  localparam logic [AW-1:0] RSV_B    = {AW{1'b1}};

  p_sel_onehot_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(mu_sel_o));

  p_sel_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mu_sel_o != '0) |=> (mu_sel_o == $past(mu_sel_o)) || (mu_sel_o == '0));

  p_grant_requester_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(|mu_sel_o) |-> |(mu_sel_o & $past(mu_irq_i)));

  p_prio_first_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(|mu_sel_o) && |($past(mu_irq_i) & PRIO_MASK)) |-> |(mu_sel_o & PRIO_MASK));

  p_first_cmd_read_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(|mu_sel_o) |-> bus_strobe_o && !bus_write_o && (bus_addr_o == CMD_ADDR));

  p_no_reserved_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_strobe_o |-> (bus_addr_o != RSV_A) && (bus_addr_o != RSV_B));

  p_strobe_selected_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_strobe_o || fb_req_o) |-> (mu_sel_o != '0));

  p_quiet_after_drop_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(|mu_sel_o) |-> !bus_strobe_o && !fb_req_o);

  p_fb_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fb_req_o && !fb_ack_i && !fb_err_i) |=>
      fb_req_o && $stable(fb_addr_o) && $stable(fb_we_o) && $stable(fb_wdata_o));
endmodule

bind mu_bus_arbiter mu_bus_arbiter_chk #(
  .NUM_MU(NUM_MU), .PRIO_MASK(PRIO_MASK), .AW(AW), .DW(DW), .FB_AW(FB_AW)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .mu_irq_i     (mu_irq_i),
  .mu_sel_o     (mu_sel_o),
  .bus_addr_o   (bus_addr_o),
  .bus_strobe_o (bus_strobe_o),
  .bus_write_o  (bus_write_o),
  .fb_req_o     (fb_req_o),
  .fb_we_o      (fb_we_o),
  .fb_addr_o    (fb_addr_o),
  .fb_wdata_o   (fb_wdata_o),
  .fb_ack_i     (fb_ack_i),
  .fb_err_i     (fb_err_i)
);

// File: tb/mu_bus_arbiter_tb_top.sv
`timescale 1ns/1ps
module mu_bus_arbiter_tb_top;
  localparam int N = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [N-1:0] irq = '0;
  logic [N-1:0] sel;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        bus_strobe, bus_write;
  logic        fb_req, fb_we;
  logic [31:0] fb_addr, fb_wdata;
  logic [31:0] fb_rdata = '0;
  logic        fb_ack = 1'b0, fb_err = 1'b0;

  always #2.5 clk = ~clk;

  mu_bus_arbiter dut_i (
    .clk_i(clk), .rst_ni(rst_n), .mu_irq_i(irq), .mu_sel_o(sel),
    .bus_addr_o(bus_addr), .bus_wdata_o(bus_wdata), .bus_rdata_i(bus_rdata),
    .bus_strobe_o(bus_strobe), .bus_write_o(bus_write),
    .fb_req_o(fb_req), .fb_we_o(fb_we), .fb_addr_o(fb_addr), .fb_wdata_o(fb_wdata),
    .fb_rdata_i(fb_rdata), .fb_ack_i(fb_ack), .fb_err_i(fb_err)
  );

  int n_tests = 0, n_fail = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // user models
  logic [31:0] mu_cmd [N];
  logic [31:0] mu_adr [N];
  logic [31:0] mu_mem [N][16];
  logic [31:0] fb_mem [64];

  always_comb begin
    bus_rdata = 32'h0;
    for (int i = 0; i < N; i++) begin
      if (sel[i]) begin
        if (bus_addr == 12'hFFC)      bus_rdata = mu_cmd[i];
        else if (bus_addr == 12'hFFD) bus_rdata = mu_adr[i];
        else if (bus_addr < 12'd16)   bus_rdata = mu_mem[i][bus_addr[3:0]];
        else                          bus_rdata = 32'hBAD0_0000 | 32'(bus_addr);
      end
    end
  end

  // reference: expected bus access stream and grant log
  int          q_wr[$];
  int          q_addr[$];
  logic [31:0] q_dat[$];
  int          got[$];
  logic [N-1:0] was_sel = '0;
  bit          abort_ok = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < N; i++) begin
        if (sel[i] && !was_sel[i]) begin
          got.push_back(i);
          q_wr.push_back(0); q_addr.push_back(12'hFFC); q_dat.push_back(0);
          q_wr.push_back(0); q_addr.push_back(12'hFFD); q_dat.push_back(0);
          for (int k = 0; k < int'(mu_cmd[i][23:0]); k++) begin
            if (mu_cmd[i][31]) begin
              q_wr.push_back(0); q_addr.push_back(k); q_dat.push_back(0);
            end else begin
              q_wr.push_back(1); q_addr.push_back(k);
              q_dat.push_back(fb_mem[(int'(mu_adr[i]) + k) % 64]);
            end
          end
        end
      end
      if (sel != '0 && !$onehot(sel)) chk("R3 select one-hot", 32'(sel), 32'h0);
      if (bus_strobe) begin
        if (sel == '0) chk("R10 strobe without select", 32'(bus_strobe), 32'h0);
        else if (q_addr.size() == 0) chk("R3 extra strobe", 32'(bus_addr), 32'hFFFF_FFFF);
        else begin
          chk("R4 R5 R6 R7 bus address", 32'(bus_addr), 32'(q_addr[0]));
          chk("R8 direction flag", 32'(bus_write), 32'(q_wr[0]));
          if (q_wr[0] != 0) chk("R8 write data", bus_wdata, q_dat[0]);
          void'(q_wr.pop_front()); void'(q_addr.pop_front()); void'(q_dat.pop_front());
        end
      end
      for (int i = 0; i < N; i++) begin
        if (sel[i] && bus_strobe && bus_write && bus_addr < 12'd16)
          mu_mem[i][bus_addr[3:0]] = bus_wdata;
        if (was_sel[i] && !sel[i]) begin
          irq[i] = 1'b0;
          if (!abort_ok) chk("R3 request completed", 32'(q_addr.size()), 32'h0);
          q_wr.delete(); q_addr.delete(); q_dat.delete();
        end
      end
      was_sel = sel;
    end
  end

  // frame-buffer model
  int          fb_lat = 0, wait_cnt = 0, words_done = 0, err_word = -1, n_fb_words = 0;
  bit          hold_pend = 1'b0;
  logic [31:0] hold_addr, hold_data;

  always @(negedge clk) begin
    if (rst_n) begin
      if (hold_pend) begin
        chk("R11 request held", 32'(fb_req), 32'h1);
        chk("R11 address stable", fb_addr, hold_addr);
        chk("R11 data stable", fb_wdata, hold_data);
      end
      if (fb_ack || fb_err) begin
        fb_ack = 1'b0;
        fb_err = 1'b0;
      end else if (fb_req) begin
        if (wait_cnt == 0) n_fb_words++;
        if (wait_cnt >= fb_lat) begin
          wait_cnt = 0;
          if (words_done == err_word) fb_err = 1'b1;
          else begin
            fb_ack = 1'b1;
            if (fb_we) fb_mem[fb_addr[5:0]] = fb_wdata;
            else       fb_rdata = fb_mem[fb_addr[5:0]];
          end
          words_done++;
        end else wait_cnt++;
      end
      hold_pend = fb_req && !fb_ack && !fb_err;
      hold_addr = fb_addr;
      hold_data = fb_wdata;
    end
  end

  task automatic setup(int i, bit to_fb, int cnt, int base);
    mu_cmd[i] = {to_fb, 7'h0, 24'(cnt)};
    mu_adr[i] = 32'(base);
    for (int k = 0; k < 16; k++) mu_mem[i][k] = 32'hA000_0000 | (i << 16) | k;
  endtask

  task automatic clear_log();
    got.delete();
    words_done = 0;
    n_fb_words = 0;
    err_word   = -1;
  endtask

  task automatic wait_done();
    int t = 0;
    while ((irq != '0 || sel != '0) && t < 2000) begin
      @(negedge clk);
      t++;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic chk_order(string req, int n, int e0, int e1, int e2, int e3);
    int e[4];
    e[0] = e0; e[1] = e1; e[2] = e2; e[3] = e3;
    chk({req, " grant count"}, 32'(got.size()), 32'(n));
    for (int k = 0; k < n && k < got.size(); k++)
      chk({req, " grant order"}, 32'(got[k]), 32'(e[k]));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int k = 0; k < 64; k++) fb_mem[k] = 32'hF000_0000 | k;
    for (int i = 0; i < N; i++) setup(i, 1'b1, 0, 0);
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 select in reset", 32'(sel), 32'h0);
    chk("R12 strobe in reset", 32'(bus_strobe), 32'h0);
    chk("R12 fb request in reset", 32'(fb_req), 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R6: user 2 writes 3 dwords to frame buffer at 8
    clear_log(); setup(2, 1'b1, 3, 8); fb_lat = 1;
    irq[2] = 1'b1; wait_done();
    for (int k = 0; k < 3; k++) chk("R6 fb word written", fb_mem[8+k], 32'hA002_0000 | k);
    chk("R6 word past end untouched", fb_mem[11], 32'hF000_000B);
    chk_order("R2", 1, 2, 0, 0, 0);

    // R7: user 1 reads 2 dwords from frame buffer at 20
    clear_log(); setup(1, 1'b0, 2, 20); fb_lat = 0;
    irq[1] = 1'b1; wait_done();
    chk("R7 user word 0", mu_mem[1][0], 32'hF000_0014);
    chk("R7 user word 1", mu_mem[1][1], 32'hF000_0015);
    chk("R7 user word 2 untouched", mu_mem[1][2], 32'hA001_0002);

    // R9: zero count
    clear_log(); setup(0, 1'b1, 0, 30);
    irq[0] = 1'b1; wait_done();
    chk("R9 no fb request", 32'(n_fb_words), 32'h0);
    chk_order("R9", 1, 0, 0, 0, 0);

    // R1 R2: all request together, ptr now past user 0
    clear_log();
    setup(0, 1'b1, 1, 32); setup(1, 1'b1, 1, 33); setup(2, 1'b1, 1, 34); setup(3, 1'b1, 1, 35);
    irq = 4'b1111; wait_done();
    chk_order("R1", 4, 1, 3, 2, 0);

    // R2: serve 2 alone, then 0 and 2 together -> 0 first
    clear_log(); setup(2, 1'b0, 1, 5);
    irq[2] = 1'b1; wait_done();
    clear_log(); setup(0, 1'b1, 1, 36); setup(2, 1'b1, 1, 37);
    irq = 4'b0101; wait_done();
    chk_order("R2", 2, 0, 2, 0, 0);

    // R3: no preemption of a running burst
    clear_log(); setup(2, 1'b1, 4, 48); setup(1, 1'b1, 1, 52); setup(0, 1'b1, 1, 53);
    fb_lat = 3;
    irq[2] = 1'b1;
    while (!sel[2]) @(negedge clk);
    irq[1] = 1'b1; irq[0] = 1'b1;
    wait_done();
    chk_order("R3", 3, 2, 1, 0, 0);
    for (int k = 0; k < 4; k++) chk("R3 burst complete", fb_mem[48+k], 32'hA002_0000 | k);

    // R10: error on second word aborts
    clear_log(); setup(3, 1'b1, 4, 40); fb_lat = 1; err_word = 1; abort_ok = 1'b1;
    irq[3] = 1'b1; wait_done();
    abort_ok = 1'b0;
    chk("R10 first word written", fb_mem[40], 32'hA003_0000);
    for (int k = 1; k < 4; k++) chk("R10 later word untouched", fb_mem[40+k], 32'hF000_0000 | (40+k));
    chk("R10 fb requests before abort", 32'(n_fb_words), 32'h2);
    chk_order("R10", 1, 3, 0, 0, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule